// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target with Write Lock

This block is a target on a two-wire serial bus that looks, from the bus, like a small serial EEPROM. It holds 256 bytes in on-chip registers. A bus controller opens a transfer with a start condition and then sends a select byte. The top nibble of that byte is the fixed family code 1010, bits 3:1 must match three strap pins, and bit 0 chooses the direction. A write transfer carries a byte address followed by data bytes, which are stored at an address pointer that steps by one after each byte. A read transfer returns bytes from the pointer, again stepping after each byte. A random read is a write transfer that carries only the address, then a repeated start and a read select.

SCL and SDA are sampled with the system clock through a synchronizer, and every edge and condition is decoded from the sampled levels. The block never drives SDA high. It has only a pull-low enable, and the board supplies the pull-up. A write-lock input protects the whole array. While the lock is high, the select and address bytes are still acknowledged, but every data byte is refused.

Top module: `i2c_ee_slave`

## Requirements
- R1: After reset the pull-low enable is 0 and all 256 locations read back as 0x00.
- R2: A select byte whose bits 7:4 are 1010 and whose bits 3:1 equal chip_sel_i[2:0] is acknowledged (SDA pulled low during the ninth clock). Any other select byte is not acknowledged, and neither are bytes clocked after it, until the next start or stop.
- R3: In a write transfer (select bit 0 = 0) the byte after the select byte is acknowledged and loads the pointer. Each later data byte is acknowledged, stored at the pointer, and the pointer then steps by one.
- R4: In a read transfer (select bit 0 = 1) the block sends the byte at the pointer MSB first and steps the pointer after each byte, so a master acknowledge is followed by the next location. The pull-low enable changes only while SCL is low.
- R5: A start seen while a transfer is open (repeated start) begins a new select byte, so address-then-read returns the byte at the address just sent.
- R6: The pointer wraps from 255 to 0, for both writing and reading.
- R7: While wr_lock_i is 1, select and address bytes are acknowledged, every data byte is not acknowledged, no location changes and the pointer does not step on data bytes.
- R8: A master not-acknowledge after a read byte ends the transfer. SDA stays released for any further clocks until the next start.
- R9: After a stop the block answers no byte until a new start.
- R10: A start in the middle of a byte discards the partial byte and restarts select-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| chip_sel_i | input | 3 | Strap value that select bits 3:1 must match |
| wr_lock_i | input | 1 | 1 refuses every data byte of a write |

## Verification
A wrong phase or bit count shows up on SDA within the same byte. The block then either pulls low in the ninth clock when it should not, stays released when it should acknowledge, or drives read bits that do not match. A wrong pointer or a stray write stays hidden until a later read reaches the affected location. For that reason, every write in the sequence is followed by a random or current-address read that covers the bytes touched, including the wrap from 255 to 0 and the locations that the lock protected.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [3:0]  DEV_FAMILY = 4'b1010;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEV,
      PH_ADDR,
      PH_WDAT,
      PH_RDAT,
      PH_SKIP
   } phase_t;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (STAGES < 1) begin : g_bad
         $error("i2c_ee_sync needs at least one stage");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= '1;
               else        stg[0] <= d_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[g] <= '1;
               else        stg[g] <= stg[g-1];
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      for (genvar w = 0; w < DEPTH; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                          mem[w] <= '0;
            else if (we && addr == ADDR_W'(w))   mem[w] <= wdata;
      end
   endgenerate

   assign rdata = mem[addr];
endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
   import i2c_ee_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic [2:0]        strap_i,
   input  logic              lock_i,
   input  logic [BYTE_W-1:0] rdata_i,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] ptr_o,
   output logic [BYTE_W-1:0] wdata_o,
   output logic              pull_o,
   output phase_t            phase_o
);
   logic scl_q, sda_q;
   logic scl_rise, scl_fall, start_c, stop_c;
   logic byte_end, ack_end, sel_hit;

   phase_t            phase;
   logic [3:0]        bitcnt;
   logic              in_ack, rd_mode, m_nack, pull;
   logic [BYTE_W-1:0] shreg, rbyte;
   logic [ADDR_W-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
   assign byte_end = scl_fall & bitcnt[3] & ~in_ack;
   assign ack_end  = scl_fall & in_ack;
   assign sel_hit  = (shreg[7:4] == DEV_FAMILY) && (shreg[3:1] == strap_i);

   assign mem_we_o = byte_end && (phase == PH_WDAT) && !lock_i;
   assign wdata_o  = shreg;
   assign ptr_o    = ptr;
   assign pull_o   = pull;
   assign phase_o  = phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         bitcnt  <= '0;
         in_ack  <= 1'b0;
         rd_mode <= 1'b0;
         m_nack  <= 1'b0;
         pull    <= 1'b0;
         shreg   <= '0;
         rbyte   <= '0;
         ptr     <= '0;
      end else if (start_c) begin
         phase  <= PH_DEV;
         bitcnt <= '0;
         in_ack <= 1'b0;
         pull   <= 1'b0;
      end else if (stop_c) begin
         phase  <= PH_IDLE;
         bitcnt <= '0;
         in_ack <= 1'b0;
         pull   <= 1'b0;
      end else begin
         case (phase)
            PH_DEV, PH_ADDR, PH_WDAT: begin
               if (scl_rise && !bitcnt[3]) begin
                  shreg  <= {shreg[BYTE_W-2:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_end) begin
                  in_ack <= 1'b1;
                  if (phase == PH_DEV) begin
                     if (sel_hit) begin
                        pull    <= 1'b1;
                        rd_mode <= shreg[0];
                     end else begin
                        phase <= PH_SKIP;
                     end
                  end else if (phase == PH_ADDR) begin
                     pull <= 1'b1;
                     ptr  <= shreg[ADDR_W-1:0];
                  end else begin
                     pull <= !lock_i;
                     if (!lock_i) ptr <= ptr + 1'b1;
                  end
               end else if (ack_end) begin
                  in_ack <= 1'b0;
                  bitcnt <= '0;
                  pull   <= 1'b0;
                  if (phase == PH_DEV) begin
                     if (rd_mode) begin
                        phase <= PH_RDAT;
                        rbyte <= rdata_i;
                        pull  <= ~rdata_i[BYTE_W-1];
                     end else begin
                        phase <= PH_ADDR;
                     end
                  end else if (phase == PH_ADDR) begin
                     phase <= PH_WDAT;
                  end
               end
            end
            PH_RDAT: begin
               if (scl_rise) begin
                  if (!bitcnt[3]) bitcnt <= bitcnt + 4'd1;
                  else if (in_ack) m_nack <= sda_s;
               end else if (scl_fall) begin
                  if (!bitcnt[3]) begin
                     pull <= ~rbyte[3'd7 - bitcnt[2:0]];
                  end else if (!in_ack) begin
                     in_ack <= 1'b1;
                     pull   <= 1'b0;
                     ptr    <= ptr + 1'b1;
                  end else begin
                     in_ack <= 1'b0;
                     if (m_nack) begin
                        phase <= PH_SKIP;
                        pull  <= 1'b0;
                     end else begin
                        rbyte  <= rdata_i;
                        pull   <= ~rdata_i[BYTE_W-1];
                        bitcnt <= '0;
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
   import i2c_ee_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o,
   input  logic [2:0] chip_sel_i,
   input  logic       wr_lock_i
);
   logic [1:0]        bus_s;
   logic              scl_s, sda_s;
   logic              mem_we;
   logic [ADDR_W-1:0] ptr;
   logic [BYTE_W-1:0] wdata, rdata;
   phase_t            phase;

   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
         $error("i2c_ee_slave: ADDR_W must lie in 1..8");
      end
   endgenerate

   i2c_ee_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (bus_s)
   );
   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   i2c_ee_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .strap_i  (chip_sel_i),
      .lock_i   (wr_lock_i),
      .rdata_i  (rdata),
      .mem_we_o (mem_we),
      .ptr_o    (ptr),
      .wdata_o  (wdata),
      .pull_o   (sda_pull_o),
      .phase_o  (phase)
   );

   i2c_ee_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .addr  (ptr),
      .wdata (wdata),
      .rdata (rdata)
   );
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk
   import i2c_ee_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              lock,
   input logic              mem_we,
   input logic [ADDR_W-1:0] ptr,
   input logic              pull,
   input phase_t            phase
);
   assert_ack_after_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> pull);

   assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> ptr == ADDR_W'($past(ptr) + 1'b1));

   assert_lock_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lock |-> !mem_we);

   assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE || phase == PH_SKIP) |-> !pull);

   assert_pull_moves_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pull) |-> !scl_s);
endmodule

bind i2c_ee_slave i2c_ee_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .scl_s  (scl_s),
   .lock   (wr_lock_i),
   .mem_we (mem_we),
   .ptr    (ptr),
   .pull   (sda_pull_o),
   .phase  (phase)
);

// File: tb/i2c_ee_slave_bench.sv
module i2c_ee_slave_bench;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_pull;
   logic [2:0] straps = 3'b101;
   logic       wp = 1'b0;
   wire        sda_line = sda_m & ~sda_pull;

   always #4 clk = ~clk;

   i2c_ee_slave u_i2c_ee_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .sda_pull_o (sda_pull),
      .chip_sel_i (straps),
      .wr_lock_i  (wp)
   );

   typedef struct { string req; int val; } item_t;
   item_t      exp_q[$];
   int         obs_q[$];
   int         checks = 0;
   int         errors = 0;
   logic [7:0] model [256];
   int         mptr = 0;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(Q);
         scl_m = 1'b0; tick(Q/2);
      end
   endtask

   task automatic write_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q/2);
      ack = !sda_line; tick(Q/2);
      scl_m = 1'b0; tick(Q/2);
   endtask

   task automatic read_byte(input bit mnack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl_m = 1'b1; tick(Q/2);
         b[i] = sda_line; tick(Q/2);
         scl_m = 1'b0;
      end
      tick(Q/2);
      sda_m = mnack; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0;
      sda_m = 1'b1; tick(Q);
   endtask

   // driver side: push expected, then push what the bus showed
   task automatic tx(input string req, input logic [7:0] b, input bit ack_exp);
      bit a;
      exp_q.push_back('{req, int'(ack_exp)});
      write_byte(b, a);
      obs_q.push_back(int'(a));
   endtask

   task automatic rx_raw(input string req, input logic [7:0] ev, input bit mnack);
      logic [7:0] r;
      exp_q.push_back('{req, int'(ev)});
      read_byte(mnack, r);
      obs_q.push_back(int'(r));
   endtask

   task automatic rx(input string req, input bit mnack);
      logic [7:0] ev;
      ev = model[mptr];
      mptr = (mptr + 1) % 256;
      rx_raw(req, ev, mnack);
   endtask

   task automatic sel(input string req, input bit rd, input bit ack_exp);
      tx(req, {4'b1010, straps, rd}, ack_exp);
   endtask

   task automatic set_addr(input string req, input logic [7:0] a);
      tx(req, a, 1'b1);
      mptr = int'(a);
   endtask

   task automatic wdat(input string req, input logic [7:0] b);
      tx(req, b, !wp);
      if (!wp) begin
         model[mptr] = b;
         mptr = (mptr + 1) % 256;
      end
   endtask

   // monitor: pops and compares as results appear
   initial begin
      forever begin
         @(negedge clk);
         while (obs_q.size() > 0) begin
            int    o;
            item_t e;
            o = obs_q.pop_front();
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL unmatched result actual=%0h expected=none", o);
            end else begin
               e = exp_q.pop_front();
               if (o != e.val) begin
                  errors++;
                  $display("FAIL %s actual=%0h expected=%0h", e.req, o, e.val);
               end
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog req=all actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      // R1: line released after reset
      exp_q.push_back('{"R1", 0});
      obs_q.push_back(int'(sda_pull));

      // R1 cleared storage, R5 random read
      bus_start(); sel("R2", 1'b0, 1'b1); set_addr("R5", 8'h42);
      bus_start(); sel("R5", 1'b1, 1'b1); rx("R1", 1'b1); bus_stop();

      // R3 sequential write
      bus_start(); sel("R3", 1'b0, 1'b1); set_addr("R3", 8'h10);
      wdat("R3", 8'hA5); wdat("R3", 8'h3C); wdat("R3", 8'h7E); bus_stop();

      // R5 random read, R4 sequential read with master acks
      bus_start(); sel("R5", 1'b0, 1'b1); set_addr("R5", 8'h10);
      bus_start(); sel("R4", 1'b1, 1'b1);
      rx("R4", 1'b0); rx("R4", 1'b0); rx("R4", 1'b1); bus_stop();

      // R4 current-address read continues at 0x13
      bus_start(); sel("R4", 1'b1, 1'b1); rx("R4", 1'b1); bus_stop();

      // R6 wrap on write and on read
      bus_start(); sel("R6", 1'b0, 1'b1); set_addr("R6", 8'hFE);
      wdat("R6", 8'h11); wdat("R6", 8'h22); wdat("R6", 8'h33); bus_stop();
      bus_start(); sel("R6", 1'b0, 1'b1); set_addr("R6", 8'hFF);
      bus_start(); sel("R6", 1'b1, 1'b1); rx("R6", 1'b0); rx("R6", 1'b1); bus_stop();

      // R2 strap mismatch, then a later byte, both unanswered
      bus_start(); tx("R2", {4'b1010, ~straps, 1'b0}, 1'b0); tx("R2", 8'h55, 1'b0); bus_stop();
      // R2 wrong family code
      bus_start(); tx("R2", {4'b1011, straps, 1'b0}, 1'b0); bus_stop();

      // R7 locked write: select and address acked, data refused
      wp = 1'b1;
      bus_start(); sel("R7", 1'b0, 1'b1); set_addr("R7", 8'h10);
      wdat("R7", 8'hFF); wdat("R7", 8'h00); bus_stop();
      wp = 1'b0;
      // R7 pointer not stepped and content kept: current read gives 0x10
      bus_start(); sel("R7", 1'b1, 1'b1); rx("R7", 1'b1); bus_stop();

      // R8 master nack ends the read; further clocks see a released line
      bus_start(); sel("R8", 1'b1, 1'b1); rx("R8", 1'b1);
      rx_raw("R8", 8'hFF, 1'b1); bus_stop();

      // R9 a byte after stop without start is not answered
      tx("R9", {4'b1010, straps, 1'b0}, 1'b0); bus_stop();

      // R10 start in the middle of a byte restarts select reception
      bus_start(); send_bits(8'hA0, 4);
      bus_start(); sel("R10", 1'b0, 1'b1); set_addr("R10", 8'h80); wdat("R10", 8'h5A); bus_stop();
      bus_start(); sel("R10", 1'b0, 1'b1); set_addr("R10", 8'h80);
      bus_start(); sel("R10", 1'b1, 1'b1); rx("R10", 1'b1); bus_stop();

      tick(20);
      if (exp_q.size() != 0) begin
         errors++;
         checks++;
         $display("FAIL pending results actual=%0d expected=0", exp_q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule